// File: doc/BRIEF.md
# Bus-Mapped Sequential Shift-Add Multiplier

This block is an unsigned 8x8 multiplier that sits on the CPU bus of a cartridge mapper. Software writes the multiplicand to one bus location and the multiplier to the neighbouring one. The write of the multiplier clears the 16-bit accumulator and starts a run of eight shift-add steps. Each step takes one rising edge of the CPU phase clock M2, so the product is complete eight bus cycles after the start.

The accumulator can be read at any moment, one byte at each of the two locations. During a run, software sees the partial products as the accumulator shifts right. The block runs on a fast core clock. It synchronises M2 into that clock and takes one bus event per M2 rising edge. The data bus is driven only while M2 is high in a read cycle that targets the register pair.

Top module: `mulbus_top`

## Requirements
- R1: After reset the accumulator is zero and the block is idle. Reads of 0x5800 and 0x5801 return 0x00, and later M2 edges do not change the accumulator.
- R2: A write cycle to 0x5800 (address bit 0 = 0) loads the multiplicand from the data bus. It leaves the accumulator unchanged, and the next multiplication uses the new value.
- R3: A write cycle to 0x5801 (address bit 0 = 1) loads the multiplier, clears the accumulator to 0x0000 and sets the step count to zero, which starts a new run.
- R4: Each M2 rising edge of a bus cycle that is not a register write performs one step, whatever the address, while fewer than 8 steps are done. After 8 steps the accumulator holds its value.
- R5: Each step consumes the multiplier bits LSB first. After k steps the accumulator equals (multiplicand x (multiplier mod 2^k)) x 2^(8-k). After 8 steps it equals the full product. For 0xFF x 0x08 the low bytes read during the run are 00,00,00,80,C0,E0,F0,F8 and the high bytes are 00,00,00,7F,3F,1F,0F,07.
- R6: A read of 0x5800 returns accumulator bits 7:0 and a read of 0x5801 returns bits 15:8. The value reflects any step taken on the M2 rising edge of that same read cycle.
- R7: cpu_data_oe_o is 1 only while M2 is high, rw is 1 (read) and the address is 0x5800 or 0x5801. Whenever cpu_data_oe_o is 0, cpu_data_o is 0x00.
- R8: A register write that lands during a run takes precedence over the step. No step is taken on that M2 edge, and the run continues on the following edges.
- R9: Write cycles to any address outside the pair load no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, faster than M2 |
| rst_ni | input | 1 | Active-low asynchronous reset |
| m2_i | input | 1 | CPU phase clock M2 (asynchronous to clk_i) |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_rw_i | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_data_i | input | 8 | CPU write data |
| cpu_data_o | output | 8 | Read data toward the CPU |
| cpu_data_oe_o | output | 1 | Output enable for cpu_data_o |

## Verification
The checks assume that address, rw and write data stay stable over a whole M2 period. They also assume that each M2 phase lasts longer than the synchroniser latency, so every rising edge gives exactly one bus event that samples settled inputs. The stimulus changes the bus only while M2 is low and holds each M2 phase for four core clocks, which is longer than the three-clock path to the event pulse. Partial products are compared after every step against the closed-form value (multiplicand x masked multiplier, shifted). This comparison is made only when the multiplicand does not change mid-run, because the closed form no longer applies after such a change.

// File: rtl/mulbus_pkg.sv
package mulbus_pkg;
  typedef struct packed {
    logic tick;   // one pulse per M2 rising edge
    logic wr_lo;  // write to operand A location
    logic wr_hi;  // write to operand B location (start)
  } bus_evt_t;
endpackage

// File: rtl/mulbus_decode.sv
module mulbus_decode
  import mulbus_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h5800,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m2_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  output bus_evt_t          evt_o,
  output logic              rd_en_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   m2_prev_q;
  logic                   hit;
  logic                   rise;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= m2_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], m2_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m2_prev_q <= 1'b0;
    else         m2_prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~m2_prev_q;
  assign hit  = (addr_i[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);

  always_comb begin
    evt_o.tick  = rise;
    evt_o.wr_lo = rise & hit & ~rw_i & ~addr_i[0];
    evt_o.wr_hi = rise & hit & ~rw_i &  addr_i[0];
  end

  // drive only during the high phase of a read to the pair
  assign rd_en_o = m2_i & rw_i & hit;
endmodule

// File: rtl/mulbus_core.sv
module mulbus_core
  import mulbus_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ACC_W = 2 * DATA_W,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_evt_t          evt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [DATA_W-1:0] mcand_q;
  logic [DATA_W-1:0] mult_q;
  logic [ACC_W-1:0]  acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              running;
  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   sum;
  logic [ACC_W-1:0]  acc_nxt;

  assign running = (cnt_q < CNT_W'(DATA_W));
  assign addend  = mult_q[0] ? mcand_q : '0;
  assign sum     = {1'b0, acc_q[ACC_W-1:DATA_W]} + {1'b0, addend};
  // carry enters the MSB as the accumulator shifts right
  assign acc_nxt = {sum, acc_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      mult_q  <= '0;
      acc_q   <= '0;
      cnt_q   <= CNT_W'(DATA_W);
    end else if (evt_i.wr_hi) begin
      mult_q <= data_i;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (evt_i.wr_lo) begin
      mcand_q <= data_i;
    end else if (evt_i.tick && running) begin
      acc_q  <= acc_nxt;
      mult_q <= mult_q >> 1;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign acc_o = acc_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/mulbus_rdmux.sv
module mulbus_rdmux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ACC_W  = 16,
  localparam int unsigned LANES = ACC_W / DATA_W,
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] lane [LANES];

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = acc_i[g*DATA_W +: DATA_W];
    end
  endgenerate

  assign oe_o   = rd_en_i;
  assign data_o = rd_en_i ? lane[sel_i] : '0;
endmodule

// File: rtl/mulbus_top.sv
module mulbus_top
  import mulbus_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h5800,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ACC_W = 2 * DATA_W,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m2_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_rw_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  output logic [DATA_W-1:0] cpu_data_o,
  output logic              cpu_data_oe_o
);
  bus_evt_t          evt;
  logic              rd_en;
  logic [ACC_W-1:0]  acc_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              wr_hi_w;
  logic              wr_any_w;

  mulbus_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .SYNC_STAGES(SYNC_STAGES)
  ) u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .m2_i   (m2_i),
    .addr_i (cpu_addr_i),
    .rw_i   (cpu_rw_i),
    .evt_o  (evt),
    .rd_en_o(rd_en)
  );

  mulbus_core #(.DATA_W(DATA_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .data_i(cpu_data_i),
    .acc_o (acc_w),
    .cnt_o (cnt_w)
  );

  mulbus_rdmux #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_rdmux (
    .acc_i  (acc_w),
    .sel_i  (cpu_addr_i[0]),
    .rd_en_i(rd_en),
    .data_o (cpu_data_o),
    .oe_o   (cpu_data_oe_o)
  );

  assign wr_hi_w  = evt.wr_hi;
  assign wr_any_w = evt.wr_hi | evt.wr_lo;
endmodule

// File: rtl/mulbus_top_chk.sv
module mulbus_top_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ACC_W = 2 * DATA_W,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              m2_i,
  input logic              cpu_rw_i,
  input logic [DATA_W-1:0] cpu_data_o,
  input logic              cpu_data_oe_o,
  input logic              wr_hi_i,
  input logic              wr_any_i,
  input logic [ACC_W-1:0]  acc_i,
  input logic [CNT_W-1:0]  cnt_i
);
  assert_oe_read_phase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_data_oe_o |-> (m2_i && cpu_rw_i));

  assert_quiet_bus_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_data_oe_o |-> (cpu_data_o == '0));

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DATA_W));

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_W'(DATA_W) && !wr_any_i) |=> $stable(acc_i));

  assert_step_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_any_i |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1));

  assert_start_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (acc_i == '0 && cnt_i == '0));
endmodule

bind mulbus_top mulbus_top_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .m2_i         (m2_i),
  .cpu_rw_i     (cpu_rw_i),
  .cpu_data_o   (cpu_data_o),
  .cpu_data_oe_o(cpu_data_oe_o),
  .wr_hi_i      (wr_hi_w),
  .wr_any_i     (wr_any_w),
  .acc_i        (acc_w),
  .cnt_i        (cnt_w)
);

// File: tb/mulbus_top_bench.sv
module mulbus_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        m2_i = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic        cpu_rw_i = 1'b1;
  logic [7:0]  cpu_data_i = '0;
  logic [7:0]  cpu_data_o;
  logic        cpu_data_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state, after the last bus cycle
  logic [7:0] m_mcand = '0;
  logic [7:0] m_mult  = '0;
  int         m_cnt   = 8;

  logic [7:0] rd;
  logic       oe_hi;
  logic       oe_lo;

  always #4 clk_i = ~clk_i;

  mulbus_top u_mulbus_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .m2_i(m2_i),
    .cpu_addr_i(cpu_addr_i), .cpu_rw_i(cpu_rw_i), .cpu_data_i(cpu_data_i),
    .cpu_data_o(cpu_data_o), .cpu_data_oe_o(cpu_data_oe_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_acc();
    logic [7:0]  mask;
    logic [31:0] p;
    mask = (m_cnt >= 8) ? 8'hFF : 8'((32'd1 << m_cnt) - 1);
    p = (32'(m_mcand) * 32'(m_mult & mask)) << 8;
    return 16'(p >> m_cnt);
  endfunction

  // one M2 period; sample read data late in the high phase
  task automatic cyc(input logic [15:0] a, input logic r, input logic [7:0] d);
    @(negedge clk_i);
    m2_i = 1'b0; cpu_addr_i = a; cpu_rw_i = r; cpu_data_i = d;
    repeat (4) @(negedge clk_i);
    oe_lo = cpu_data_oe_o;
    m2_i = 1'b1;
    repeat (4) @(negedge clk_i);
    rd = cpu_data_o;
    oe_hi = cpu_data_oe_o;
    m2_i = 1'b0;
    if (!r && a == 16'h5800) m_mcand = d;
    else if (!r && a == 16'h5801) begin m_mult = d; m_cnt = 0; end
    else if (m_cnt < 8) m_cnt++;
  endtask

  task automatic rd_lo(input string tag);
    cyc(16'h5800, 1'b1, 8'h00);
    chk({tag, " oe"}, 32'(oe_hi), 32'd1);
    chk({tag, " lo R6"}, 32'(rd), 32'(exp_acc() & 16'h00FF));
  endtask

  task automatic rd_hi(input string tag);
    cyc(16'h5801, 1'b1, 8'h00);
    chk({tag, " oe"}, 32'(oe_hi), 32'd1);
    chk({tag, " hi R6"}, 32'(rd), 32'(exp_acc() >> 8));
  endtask

  task automatic test_reset();
    cyc(16'h5800, 1'b1, 8'h00);
    chk("R1 reset lo", 32'(rd), 32'h00);
    cyc(16'h5801, 1'b1, 8'h00);
    chk("R1 reset hi", 32'(rd), 32'h00);
    chk("R1 reset oe", 32'(oe_hi), 32'd1);
  endtask

  task automatic test_clear_then_doc();
    logic [7:0] lo_seq [8] = '{8'h00, 8'h00, 8'h00, 8'h80, 8'hC0, 8'hE0, 8'hF0, 8'hF8};
    logic [7:0] hi_seq [8] = '{8'h00, 8'h00, 8'h00, 8'h7F, 8'h3F, 8'h1F, 8'h0F, 8'h07};
    cyc(16'h5800, 1'b0, 8'h00);
    cyc(16'h5801, 1'b0, 8'h00);
    for (int i = 0; i < 8; i++) cyc(16'h5802, 1'b1, 8'h00);
    rd_lo("R3 zero clear");
    rd_hi("R3 zero clear");
    cyc(16'h5800, 1'b0, 8'hFF);
    cyc(16'h5801, 1'b0, 8'h08);
    for (int i = 0; i < 8; i++) begin
      cyc(16'h5800, 1'b1, 8'h00);
      chk("R5 doc lo seq", 32'(rd), 32'(lo_seq[i]));
    end
    cyc(16'h5801, 1'b0, 8'h08);
    for (int i = 0; i < 8; i++) begin
      cyc(16'h5801, 1'b1, 8'h00);
      chk("R5 doc hi seq", 32'(rd), 32'(hi_seq[i]));
    end
  endtask

  task automatic run_pair(input logic [7:0] a, input logic [7:0] b);
    cyc(16'h5800, 1'b0, a);
    cyc(16'h5801, 1'b0, b);
    chk("R2 oe on write", 32'(oe_hi), 32'd0);
    for (int k = 0; k < 8; k++) begin
      if (k[0]) rd_hi("R5 partial");
      else      rd_lo("R5 partial");
    end
    rd_lo("R5 final");
    chk("R5 product lo", 32'(rd), 32'((16'(a) * 16'(b)) & 16'h00FF));
    rd_hi("R5 final");
    chk("R5 product hi", 32'(rd), 32'((16'(a) * 16'(b)) >> 8));
  endtask

  task automatic test_products();
    run_pair(8'hFF, 8'hFF);
    run_pair(8'h00, 8'hA5);
    run_pair(8'h01, 8'h01);
    run_pair(8'h80, 8'h80);
    for (int i = 0; i < 16; i++) run_pair(8'($urandom), 8'($urandom));
  endtask

  task automatic test_hold();
    logic [15:0] fin;
    run_pair(8'hC3, 8'h5A);
    fin = 16'h00C3 * 16'h005A;
    for (int i = 0; i < 6; i++) begin
      cyc(16'h5800 + 16'(i % 2), 1'b1, 8'h00);
      chk("R4 hold after 8", 32'(rd), 32'((i % 2) ? fin[15:8] : fin[7:0]));
    end
  endtask

  task automatic test_mid_write();
    // mcand rewrite with same value: that edge takes no step
    cyc(16'h5800, 1'b0, 8'hB7);
    cyc(16'h5801, 1'b0, 8'hE9);
    rd_lo("R8 pre");
    rd_hi("R8 pre");
    cyc(16'h5800, 1'b0, 8'hB7);
    rd_hi("R8 after lo write");
    for (int i = 0; i < 6; i++) rd_lo("R8 continue");
    rd_hi("R8 end");
    chk("R8 product", 32'(rd), 32'((16'hB7 * 16'hE9) >> 8));
    // restart mid-run
    cyc(16'h5801, 1'b0, 8'h33);
    rd_lo("R3 restart");
    cyc(16'h5801, 1'b0, 8'h0F);
    rd_hi("R3 restart 2");
    for (int i = 0; i < 8; i++) rd_lo("R3 restart run");
    chk("R3 restart product", 32'(rd), 32'((16'hB7 * 16'h0F) & 16'h00FF));
  endtask

  task automatic test_bus_release();
    cyc(16'h5800, 1'b0, 8'h21);
    chk("R7 write oe", 32'(oe_hi), 32'd0);
    chk("R7 write data", 32'(cpu_data_o), 32'd0);
    cyc(16'h5801, 1'b0, 8'h13);
    cyc(16'h5802, 1'b1, 8'h00);
    chk("R7 foreign read oe", 32'(oe_hi), 32'd0);
    chk("R7 foreign read data", 32'(rd), 32'd0);
    cyc(16'h4800, 1'b1, 8'h00);
    chk("R7 far read oe", 32'(oe_hi), 32'd0);
    // foreign writes still clock steps but load nothing
    cyc(16'h5802, 1'b0, 8'hFF);
    cyc(16'h5803, 1'b0, 8'hFF);
    cyc(16'hD800, 1'b0, 8'hFF);
    cyc(16'h5800, 1'b1, 8'h00);
    chk("R7 low phase oe", 32'(oe_lo), 32'd0);
    for (int i = 0; i < 3; i++) rd_hi("R9 foreign write");
    chk("R9 product", 32'(rd), 32'((16'h21 * 16'h13) >> 8));
    rd_lo("R9 foreign write lo");
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    test_clear_then_doc();
    test_products();
    test_hold();
    test_mid_write();
    test_bus_release();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule